// File: doc/BRIEF.md
# Serial CRC-16 Generator and Checker

This block computes a 16-bit cyclic redundancy check one bit per clock using the generator polynomial x^16 + x^15 + x^2 + 1. A message is presented as a stream of bits with a valid strobe. The first bit presented is the coefficient of the highest power of the message polynomial. The engine keeps the remainder of the message polynomial times x^16, divided by the generator. The remainder never needs more than 16 bits, whatever the message length.

The same engine serves both ends of a link. A sender streams its data and then reads `crc_word`, which is the check value to append. A receiver streams the data followed by that appended word, and then reads `crc_zero`. A high `crc_zero` means the remainder is zero, so no error was detected.

Data words use this convention: bit 15 of a word holds the x^0 coefficient and bit 0 holds the x^15 coefficient. A word is therefore fed starting from its bit 0. The appended check word follows the same convention, which makes `crc_word` the remainder in reversed coefficient order. `start` begins a new block, and `clear` empties the register at any time.

Top module: `crc16_serial`

## Requirements
- R1: While `rst` is high, the remainder register is set to zero. After reset, `crc_word` reads 0x0000 and `crc_zero` reads 1.
- R2: Each cycle with `din_valid` high advances the remainder by one division step of x^16 + x^15 + x^2 + 1, with `din` taken as the next lower-power message coefficient. After a block of N bits, the register holds (M(x)·x^16) mod G(x).
- R3: `crc_word` presents the remainder with the x^0 coefficient at bit 15 and the x^15 coefficient at bit 0. The 16-bit message word 0x26F0, fed from bit 0 to bit 15, yields `crc_word` = 0xDAC5. A single 1 bit after `start` yields 0xA001.
- R4: In a cycle with `din_valid`, `start` and `clear` all low, the register is unchanged. Idle cycles inserted anywhere in a block do not change its result.
- R5: `clear` high sets the register to zero at the next edge. It takes priority over `start` and `din_valid`, and the `din` of that cycle is discarded.
- R6: `start` high without `clear` restarts the block from a zero register. If `din_valid` is also high, that cycle's `din` is processed as the first bit of the new block. If `din_valid` is low, the register becomes zero.
- R7: A block made of message bits followed by that message's `crc_word`, fed from bit 0 to bit 15, leaves `crc_zero` = 1. A single inverted bit anywhere in such a block leaves `crc_zero` = 0.
- R8: `crc_zero` is 1 exactly when all 16 register bits are zero. It changes in the same cycle as `crc_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Empty the remainder register (highest priority) |
| start | input | 1 | Begin a new block; with din_valid, din is its first bit |
| din_valid | input | 1 | Qualifies din; the register shifts only when high |
| din | input | 1 | Serial message bit, highest power first |
| crc_word | output | 16 | Remainder in reversed coefficient order (word to append) |
| crc_zero | output | 1 | High when the remainder is zero |

## Verification
Every one-byte message is compared with a polynomial long division done in the bench. This separates a wrong feedback tap or bit order from a correct one, since each of the 256 patterns exercises a different set of taps. The 0x26F0 word pins down the coefficient-reversal convention of the output. Walking-one words and all bytes, each with its check word appended, show that a clean block ends at zero. Inverting each of the 32 bits of a protected block in turn shows that no single-bit error leaves a zero remainder. Idle gaps, mid-block `clear` and mid-block `start` are placed inside known blocks, so a hold, a priority or a restart fault changes a known answer.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int CRC_W = 16;
    // Generator taps below x^16 (x^15 + x^2 + 1); the x^16 term is implicit
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_ZERO  = 2'd1,
        ACT_SHIFT = 2'd2,
        ACT_SEED  = 2'd3
    } crc_act_e;

    typedef struct packed {
        logic clr;
        logic start;
        logic valid;
        logic bit_in;
    } crc_req_t;

    // Priority: clear, then start, then valid
    function automatic crc_act_e crc_decide(input crc_req_t q);
        crc_act_e a;
        if (q.clr)
            a = ACT_ZERO;
        else if (q.start)
            a = q.valid ? ACT_SEED : ACT_ZERO;
        else
            a = q.valid ? ACT_SHIFT : ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/crc16_step.sv
module crc16_step #(
    parameter int                W    = crc16_pkg::CRC_W,
    parameter logic [W-1:0]      POLY = crc16_pkg::CRC_POLY
) (
    input  logic [W-1:0] cur,
    input  logic         bit_in,
    output logic [W-1:0] nxt
);
    logic fb;
    assign fb = bit_in ^ cur[W-1];

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == 0) begin : g_lsb
            assign nxt[i] = fb & POLY[i];
        end else begin : g_mid
            assign nxt[i] = cur[i-1] ^ (fb & POLY[i]);
        end
    end
endmodule

// File: rtl/crc16_state.sv
module crc16_state
    import crc16_pkg::*;
#(
    parameter int           W    = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY
) (
    input  logic         clk,
    input  logic         rst,
    input  crc_req_t     req,
    output logic [W-1:0] state
);
    crc_act_e     act;
    logic [W-1:0] src;
    logic [W-1:0] stepped;

    assign act = crc_decide(req);
    assign src = (act == ACT_SEED) ? '0 : state;

    crc16_step #(.W(W), .POLY(POLY)) u_step (
        .cur    (src),
        .bit_in (req.bit_in),
        .nxt    (stepped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else begin
            unique case (act)
                ACT_ZERO:  state <= '0;
                ACT_SHIFT: state <= stepped;
                ACT_SEED:  state <= stepped;
                default:   state <= state;
            endcase
        end
    end
endmodule

// File: rtl/crc16_outmap.sv
module crc16_outmap #(
    parameter int W = crc16_pkg::CRC_W
) (
    input  logic [W-1:0] state,
    output logic [W-1:0] word,
    output logic         is_zero
);
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign word[i] = state[W-1-i];
    end
    assign is_zero = ~|state;
endmodule

// File: rtl/crc16_serial.sv
module crc16_serial
    import crc16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        start,
    input  logic        din_valid,
    input  logic        din,
    output logic [15:0] crc_word,
    output logic        crc_zero
);
    crc_req_t req;
    crc_t     rem_q;

    assign req = '{clr: clear, start: start, valid: din_valid, bit_in: din};

    crc16_state #(.W(CRC_W), .POLY(CRC_POLY)) u_state (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .state (rem_q)
    );

    crc16_outmap #(.W(CRC_W)) u_out (
        .state   (rem_q),
        .word    (crc_word),
        .is_zero (crc_zero)
    );
endmodule

// File: rtl/crc16_serial_chk.sv
module crc16_serial_chk (
    input logic        clk,
    input logic        rst,
    input logic        clear,
    input logic        start,
    input logic        din_valid,
    input logic        din,
    input logic [15:0] crc_word,
    input logic        crc_zero
);
    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (crc_zero && crc_word == 16'h0000)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clear && !start && !din_valid) |=> $stable(crc_word)); // R4

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clear |=> crc_zero); // R5

    AST_START_NOBIT: assert property (@(posedge clk) disable iff (rst)
        (start && !clear && !din_valid) |=> crc_zero); // R6

    AST_START_FIRST: assert property (@(posedge clk) disable iff (rst)
        (start && !clear && din_valid) |=> (crc_word == ($past(din) ? 16'hA001 : 16'h0000))); // R6

    always @(posedge clk) begin
        if (!rst) begin
            AST_ZERO_MATCH: assert (crc_zero == (crc_word == 16'h0000)); // R8
        end
    end
endmodule

bind crc16_serial crc16_serial_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .start     (start),
    .din_valid (din_valid),
    .din       (din),
    .crc_word  (crc_word),
    .crc_zero  (crc_zero)
);

// File: tb/sim_crc16_serial.sv
`timescale 1ns/1ps
module sim_crc16_serial;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clear = 1'b0, start = 1'b0, din_valid = 1'b0, din = 1'b0;
    logic [15:0] crc_word;
    logic        crc_zero;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    crc16_serial u0 (
        .clk(clk), .rst(rst), .clear(clear), .start(start),
        .din_valid(din_valid), .din(din),
        .crc_word(crc_word), .crc_zero(crc_zero)
    );

    // Long division of M(x)*x^16 by x^16+x^15+x^2+1; s[j] is the j-th bit fed, power n-1-j
    function automatic logic [15:0] ref_rem(input logic [63:0] s, input int n);
        logic [79:0] d = '0;
        for (int j = 0; j < n; j++) d[n - 1 - j + 16] = s[j];
        for (int i = n + 15; i >= 16; i--)
            if (d[i]) d = d ^ (80'h18005 << (i - 16));
        return d[15:0];
    endfunction

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15 - i];
        return r;
    endfunction

    task automatic drive(input logic c, input logic st, input logic v, input logic d);
        @(negedge clk);
        clear = c; start = st; din_valid = v; din = d;
    endtask

    task automatic feed(input logic [63:0] s, input int n);
        drive(0, 1, 1, s[0]);
        for (int j = 1; j < n; j++) drive(0, 0, 1, s[j]);
        drive(0, 0, 0, 0);
    endtask

    task automatic check(input string req, input logic [15:0] got_w, input logic [15:0] exp_w,
                         input logic got_z, input logic exp_z);
        checks++;
        if (got_w !== exp_w || got_z !== exp_z) begin
            errors++;
            $display("FAIL %s: crc_word=%h crc_zero=%b expected crc_word=%h crc_zero=%b",
                     req, got_w, got_z, exp_w, exp_z);
        end
    endtask

    task automatic check_zero(input string req, input logic exp_z);
        checks++;
        if (crc_zero !== exp_z) begin
            errors++;
            $display("FAIL %s: crc_zero=%b expected %b", req, crc_zero, exp_z);
        end
    endtask

    initial begin
        logic [63:0] s;
        logic [15:0] e, held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(0, 0, 0, 0);
        check("R1 reset state", crc_word, 16'h0000, crc_zero, 1'b1);

        // R3 known answers
        s = 64'h26F0;
        feed(s, 16);
        check("R3 word 26F0", crc_word, 16'hDAC5, crc_zero, 1'b0);
        s = 64'h1;
        feed(s, 1);
        check("R3 single one", crc_word, 16'hA001, crc_zero, 1'b0);

        // R2 and R8: every byte against long division
        for (int b = 0; b < 256; b++) begin
            s = 64'(b);
            feed(s, 8);
            e = rev16(ref_rem(s, 8));
            check("R2 byte sweep", crc_word, e, crc_zero, e == 16'h0000);
        end

        // R7: bytes with their check word appended
        for (int b = 0; b < 256; b++) begin
            s = 64'(b);
            e = rev16(ref_rem(s, 8));
            s[23:8] = e;
            feed(s, 24);
            check_zero("R7 byte plus check", 1'b1);
        end

        // R7: walking-one words with check appended
        for (int k = 0; k < 16; k++) begin
            s = 64'(1) << k;
            e = rev16(ref_rem(s, 16));
            s[31:16] = e;
            feed(s, 32);
            check_zero("R7 walking one", 1'b1);
        end

        // R7: each single-bit error in the protected 26F0 block
        for (int k = 0; k < 32; k++) begin
            s = {32'h0, 16'hDAC5, 16'h26F0};
            s[k] = ~s[k];
            feed(s, 32);
            check_zero("R7 single bit error", 1'b0);
        end

        // R4: idle gaps inside the block, and stability while idle
        s = 64'h26F0;
        drive(0, 1, 1, s[0]);
        for (int j = 1; j < 16; j++) begin
            drive(0, 0, 0, 0);
            drive(0, 0, 0, 1);
            drive(0, 0, 1, s[j]);
        end
        drive(0, 0, 0, 0);
        held = crc_word;
        check("R4 gapped block", crc_word, 16'hDAC5, crc_zero, 1'b0);
        repeat (4) drive(0, 0, 0, 1);
        check("R4 idle hold", crc_word, held, crc_zero, 1'b0);

        // R5: clear with valid and start beside it
        s = 64'h26F0;
        feed(s, 10);
        drive(1, 1, 1, 1);
        drive(0, 0, 0, 0);
        check("R5 clear priority", crc_word, 16'h0000, crc_zero, 1'b1);
        feed(s, 10);
        drive(1, 0, 1, 1);
        drive(0, 0, 0, 0);
        check("R5 clear over valid", crc_word, 16'h0000, crc_zero, 1'b1);

        // R6: start mid block restarts; start alone empties
        s = 64'hFFFF;
        feed(s, 7);
        s = 64'h26F0;
        feed(s, 16);
        check("R6 restart block", crc_word, 16'hDAC5, crc_zero, 1'b0);
        drive(0, 1, 0, 1);
        drive(0, 0, 0, 0);
        check("R6 start without bit", crc_word, 16'h0000, crc_zero, 1'b1);

        // R1: reset mid block
        s = 64'h26F0;
        feed(s, 9);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset mid block", crc_word, 16'h0000, crc_zero, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule